// File: doc/BRIEF.md
# Broadcast audio output route controller

This block decides where the two audio outputs of a broadcast sound decoder take their signal from. It also decides what feeds the noise-reduction expander and whether the second-language path is soft-muted. It takes user control bits, two test bits and three detector flags: stereo pilot present, second-language carrier present, and excess noise. It produces registered select codes that a separate signal path uses to steer its multiplexers.

The controls follow a fixed priority. The DAC test bit comes first, then the filter test bit, then the user unmute bit, and last the group made of mode (stereo or second language), forced mono and carrier policy. The detector flags come from analog detectors and can flicker on weak signals. Each flag is therefore filtered: a new value is accepted only after it has held steady for a programmable number of clocks. The select codes then change without audible toggling.

Top module: `aud_route_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, left and right select codes are 0 (mute), the expander select is 0 (mute), and soft mute is 1.
- R2: With test_dac=1, left is 7 (DAC level) and right is 8 (stereo VCO clock), whatever the other controls.
- R3: With test_dac=0 and test_filt=1, left is 5 (second-language band-pass) and right is 6 (noise-reduction band-pass).
- R4: With both test bits 0 and unmute=0, left and right are 0 (mute).
- R5: With no test bit set, unmute=1, fomo=0 and no second-language output chosen, left/right are 1/2 (L/R) when stereo is detected, else 3/3 (L+R).
- R6: With sap_mode=1 and sap_force=1 (no test, unmuted, fomo=0), both outputs are 4 (second language), whether or not the carrier is detected.
- R7: With sap_mode=1 and sap_force=0, both outputs are 4 only when the carrier is detected; otherwise the result is that of R5.
- R8: With fomo=1 (no test, unmuted), left is 3 (L+R). Right is 4 when second-language output is chosen (sap_mode and (sap_force or carrier)), else 3.
- R9: Soft mute is 1 when the filtered carrier flag is 0 or the filtered noise flag is 1, else 0.
- R10: The expander select is 2 (second language) when second-language output is chosen, else 1 (L-R) when stereo is detected and fomo=0, else 0 (mute). It does not depend on the test or unmute bits.
- R11: A control input change shows on the outputs one edge later. A detector flag change shows HOLD_CYCLES+1 edges later, and only if it holds for HOLD_CYCLES consecutive edges. A shorter pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sap_mode | input | 1 | 0 stereo mode, 1 second-language mode |
| fomo | input | 1 | Forced mono |
| sap_force | input | 1 | 1: second language even without carrier |
| unmute | input | 1 | 0 mutes both outputs |
| test_filt | input | 1 | Filter test routing |
| test_dac | input | 1 | DAC / VCO test routing |
| det_stereo | input | 1 | Stereo pilot detected (raw) |
| det_sap | input | 1 | Second-language carrier detected (raw) |
| det_noise | input | 1 | Excess noise detected (raw) |
| left_sel | output | 4 | Left output source code |
| right_sel | output | 4 | Right output source code |
| nr_sel | output | 2 | Expander input source code |
| sap_soft_mute | output | 1 | Soft-mute the second-language path |

## Verification
Control bits reach the outputs through one register, so each control pattern is applied at a falling edge and checked at the next falling edge. Detector flags pass through the filter and then the output register, so they are due HOLD_CYCLES+1 edges after they change. The sweep sets each flag pattern and waits past that point before it walks all 64 control patterns. A dedicated test samples one edge before and exactly at the flag deadline, and it checks that a pulse one cycle too short never reaches the outputs.

// File: rtl/aud_route_pkg.sv
package aud_route_pkg;
  localparam int SEL_W = 4;
  localparam int NR_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_MUTE   = 4'd0,
    SRC_LEFT   = 4'd1,
    SRC_RIGHT  = 4'd2,
    SRC_SUM    = 4'd3,
    SRC_SAP    = 4'd4,
    SRC_SAPBPF = 4'd5,
    SRC_NRBPF  = 4'd6,
    SRC_DAC    = 4'd7,
    SRC_VCO    = 4'd8
  } src_t;

  typedef enum logic [NR_W-1:0] {
    NR_MUTE = 2'd0,
    NR_DIFF = 2'd1,
    NR_SAP  = 2'd2
  } nr_t;
endpackage

// File: rtl/aud_flag_filter.sv
module aud_flag_filter #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CNT_W = $clog2(HOLD_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      filt <= raw;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11: the filtered flag only ever moves to the value the raw input had
  p_follow_raw_r11: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> (filt == $past(raw)));

  // R11: the run counter never passes the hold window
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(HOLD_CYCLES));
endmodule

// File: rtl/aud_route_resolve.sv
module aud_route_resolve
  import aud_route_pkg::*;
(
  input  logic sap_mode,
  input  logic fomo,
  input  logic sap_force,
  input  logic unmute,
  input  logic test_filt,
  input  logic test_dac,
  input  logic st_ok,
  input  logic sap_ok,
  input  logic noise_ok,
  output src_t left_nxt,
  output src_t right_nxt,
  output nr_t  nr_nxt,
  output logic soft_nxt
);
  logic sap_out;

  always_comb begin
    sap_out = sap_mode && (sap_force || sap_ok);

    if (test_dac) begin
      left_nxt  = SRC_DAC;
      right_nxt = SRC_VCO;
    end else if (test_filt) begin
      left_nxt  = SRC_SAPBPF;
      right_nxt = SRC_NRBPF;
    end else if (!unmute) begin
      left_nxt  = SRC_MUTE;
      right_nxt = SRC_MUTE;
    end else if (fomo) begin
      left_nxt  = SRC_SUM;
      right_nxt = sap_out ? SRC_SAP : SRC_SUM;
    end else if (sap_out) begin
      left_nxt  = SRC_SAP;
      right_nxt = SRC_SAP;
    end else if (st_ok) begin
      left_nxt  = SRC_LEFT;
      right_nxt = SRC_RIGHT;
    end else begin
      left_nxt  = SRC_SUM;
      right_nxt = SRC_SUM;
    end

    if (sap_out)            nr_nxt = NR_SAP;
    else if (st_ok && !fomo) nr_nxt = NR_DIFF;
    else                    nr_nxt = NR_MUTE;

    soft_nxt = !sap_ok || noise_ok;
  end
endmodule

// File: rtl/aud_route_ctrl.sv
module aud_route_ctrl
  import aud_route_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sap_mode,
  input  logic             fomo,
  input  logic             sap_force,
  input  logic             unmute,
  input  logic             test_filt,
  input  logic             test_dac,
  input  logic             det_stereo,
  input  logic             det_sap,
  input  logic             det_noise,
  output logic [SEL_W-1:0] left_sel,
  output logic [SEL_W-1:0] right_sel,
  output logic [NR_W-1:0]  nr_sel,
  output logic             sap_soft_mute
);
  localparam int NFLAG = 3;

  logic [NFLAG-1:0] raw_flags;
  logic [NFLAG-1:0] ok_flags;
  src_t left_nxt, right_nxt;
  nr_t  nr_nxt;
  logic soft_nxt;

  assign raw_flags = {det_noise, det_sap, det_stereo};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flt
    aud_flag_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_flt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_flags[g]),
      .filt (ok_flags[g])
    );
  end

  aud_route_resolve u_res (
    .sap_mode  (sap_mode),
    .fomo      (fomo),
    .sap_force (sap_force),
    .unmute    (unmute),
    .test_filt (test_filt),
    .test_dac  (test_dac),
    .st_ok     (ok_flags[0]),
    .sap_ok    (ok_flags[1]),
    .noise_ok  (ok_flags[2]),
    .left_nxt  (left_nxt),
    .right_nxt (right_nxt),
    .nr_nxt    (nr_nxt),
    .soft_nxt  (soft_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_sel      <= SRC_MUTE;
      right_sel     <= SRC_MUTE;
      nr_sel        <= NR_MUTE;
      sap_soft_mute <= 1'b1;
    end else begin
      left_sel      <= left_nxt;
      right_sel     <= right_nxt;
      nr_sel        <= nr_nxt;
      sap_soft_mute <= soft_nxt;
    end
  end

  p_dac_first_r2: assert property (@(posedge clk) disable iff (rst)
    test_dac |=> (left_sel == SRC_DAC && right_sel == SRC_VCO));

  p_filt_test_r3: assert property (@(posedge clk) disable iff (rst)
    (!test_dac && test_filt) |=> (left_sel == SRC_SAPBPF && right_sel == SRC_NRBPF));

  p_mute_r4: assert property (@(posedge clk) disable iff (rst)
    (!test_dac && !test_filt && !unmute) |=> (left_sel == SRC_MUTE && right_sel == SRC_MUTE));

  p_mono_left_r8: assert property (@(posedge clk) disable iff (rst)
    (!test_dac && !test_filt && unmute && fomo) |=> (left_sel == SRC_SUM));

  p_sap_forced_r6: assert property (@(posedge clk) disable iff (rst)
    (!test_dac && !test_filt && unmute && !fomo && sap_mode && sap_force)
      |=> (left_sel == SRC_SAP && right_sel == SRC_SAP && nr_sel == NR_SAP));

  p_nr_code_r10: assert property (@(posedge clk) disable iff (rst)
    nr_sel <= NR_SAP);
endmodule

// File: tb/aud_route_ctrl_tb.sv
`timescale 1ns/1ps
module aud_route_ctrl_tb;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sap_mode = 0, fomo = 0, sap_force = 0, unmute = 0, test_filt = 0, test_dac = 0;
  logic det_stereo = 0, det_sap = 0, det_noise = 0;
  logic [3:0] left_sel, right_sel;
  logic [1:0] nr_sel;
  logic sap_soft_mute;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aud_route_ctrl #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst(rst), .sap_mode(sap_mode), .fomo(fomo), .sap_force(sap_force),
    .unmute(unmute), .test_filt(test_filt), .test_dac(test_dac),
    .det_stereo(det_stereo), .det_sap(det_sap), .det_noise(det_noise),
    .left_sel(left_sel), .right_sel(right_sel), .nr_sel(nr_sel),
    .sap_soft_mute(sap_soft_mute)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected pair {left,right} from the requirement text
  function automatic logic [7:0] exp_lr(logic [5:0] c, logic st, logic sp);
    logic dac, flt, um, fm, sm, sf, out_sap;
    {dac, flt, um, fm, sf, sm} = c;
    out_sap = sm && (sf || sp);
    if (dac)          return {4'd7, 4'd8};
    else if (flt)     return {4'd5, 4'd6};
    else if (!um)     return {4'd0, 4'd0};
    else if (fm)      return {4'd3, out_sap ? 4'd4 : 4'd3};
    else if (out_sap) return {4'd4, 4'd4};
    else if (st)      return {4'd1, 4'd2};
    else              return {4'd3, 4'd3};
  endfunction

  function automatic string lr_req(logic [5:0] c);
    logic dac, flt, um, fm, sm, sf;
    {dac, flt, um, fm, sf, sm} = c;
    if (dac) return "R2";
    if (flt) return "R3";
    if (!um) return "R4";
    if (fm)  return "R8";
    if (sm)  return sf ? "R6" : "R7";
    return "R5";
  endfunction

  function automatic logic [1:0] exp_nr(logic [5:0] c, logic st, logic sp);
    logic fm, sm, sf;
    fm = c[2]; sf = c[1]; sm = c[0];
    if (sm && (sf || sp)) return 2'd2;
    if (st && !fm)        return 2'd1;
    return 2'd0;
  endfunction

  initial begin
    wait_neg(2);
    check("R1 reset", {left_sel, right_sel, 6'd0, nr_sel, sap_soft_mute},
          {4'd0, 4'd0, 6'd0, 2'd0, 1'b1});
    rst = 1'b0;
    // first edge after reset: controls were mute-all, flags zero
    wait_neg(1);
    check("R1 after", {left_sel, right_sel, 6'd0, nr_sel, sap_soft_mute},
          {4'd0, 4'd0, 6'd0, 2'd0, 1'b1});

    // sweep every flag pattern and every control pattern
    for (int f = 0; f < 8; f++) begin
      {det_noise, det_sap, det_stereo} = f[2:0];
      wait_neg(HOLD + 3);
      for (int c = 0; c < 64; c++) begin
        {test_dac, test_filt, unmute, fomo, sap_force, sap_mode} = c[5:0];
        wait_neg(1);
        check(lr_req(c[5:0]), {8'd0, left_sel, right_sel},
              {8'd0, exp_lr(c[5:0], f[0], f[1])});
        check("R10 nr", {14'd0, nr_sel}, {14'd0, exp_nr(c[5:0], f[0], f[1])});
        check("R9 soft", {15'd0, sap_soft_mute}, {15'd0, (!f[1]) || f[2]});
      end
    end

    // R11: stereo flag deadline in stereo mode
    {test_dac, test_filt, unmute, fomo, sap_force, sap_mode} = 6'b001000;
    {det_noise, det_sap, det_stereo} = 3'b000;
    wait_neg(HOLD + 3);
    check("R11 base", {8'd0, left_sel, right_sel}, {8'd0, 4'd3, 4'd3});
    det_stereo = 1'b1;
    wait_neg(HOLD);
    check("R11 early", {8'd0, left_sel, right_sel}, {8'd0, 4'd3, 4'd3});
    wait_neg(1);
    check("R11 due", {8'd0, left_sel, right_sel}, {8'd0, 4'd1, 4'd2});

    // R11: pulse one cycle short is ignored
    det_stereo = 1'b0;
    wait_neg(HOLD + 3);
    det_stereo = 1'b1;
    wait_neg(HOLD - 1);
    det_stereo = 1'b0;
    wait_neg(HOLD + 3);
    check("R11 glitch", {8'd0, left_sel, right_sel}, {8'd0, 4'd3, 4'd3});
    check("R11 glitch nr", {14'd0, nr_sel}, {14'd0, 2'd0});

    // R11: control change is one edge
    unmute = 1'b0;
    wait_neg(1);
    check("R11 ctrl R4", {8'd0, left_sel, right_sel}, {8'd0, 4'd0, 4'd0});

    // R9: short carrier pulse leaves soft mute on
    det_sap = 1'b1;
    wait_neg(HOLD - 1);
    det_sap = 1'b0;
    wait_neg(HOLD + 2);
    check("R9 glitch", {15'd0, sap_soft_mute}, {15'd0, 1'b1});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule